// File: doc/BRIEF.md
# PCI Configuration Status Register with System-Error Output

This block holds the 16-bit status half of a PCI device's command/status configuration dword and drives the device's active-low system-error line. The surrounding bus engine reports error conditions as single-cycle event strobes: parity errors seen as master or as target, target aborts that the device signalled or received, and master aborts that it received. Each strobe latches a sticky flag. Software clears a flag by writing a 1 to its bit position through a byte-enabled configuration write.

Two fields are read-only. One reports support for a capability list and is the registered inverse of a power-management mode input. The other is a fixed DEVSEL decode-speed code for medium timing. The block also produces the system-error pulse when that output is enabled by the command register's enable bit. An address parity error on a normal target cycle qualifies, and so does a data parity error on a special cycle. Every such pulse also latches the signalled-system-error flag.

Top module: `pci_stat_reg`

## Requirements
- R1: A synchronous reset that is active high puts `status_o` at 16'h0210 and `serr_n_o` at 1, whatever the other inputs are.
- R2: Bit 4 of `status_o` reads the inverse of `acpi_mode` as sampled at the previous clock edge. Writes do not change it.
- R3: Bits 10:9 always read 2'b01. Bits 7:5 and 3:0 always read 0. Writes to these bits have no effect.
- R4: Bit 8 becomes 1 in the clock after `ev_data_perr_mst` is high.
- R5: Bits 11, 12 and 13 become 1 in the clock after `ev_tgt_abort_sent`, `ev_tgt_abort_rcvd` and `ev_mst_abort_rcvd` respectively.
- R6: Bit 15 becomes 1 after any of `ev_addr_perr_tgt`, `ev_data_perr_spec` or `ev_data_perr_mst`. This happens whatever the value of `serr_en`.
- R7: `serr_n_o` is 0 for exactly the one clock that follows a cycle in which `serr_en` is 1 and either `ev_addr_perr_tgt` or `ev_data_perr_spec` is 1. In every other clock it is 1.
- R8: Bit 14 becomes 1 in the same clock in which `serr_n_o` goes to 0.
- R9: When `cfg_wr` is 1, a 1 in `cfg_wdata[16+k]` clears sticky status bit k, provided the byte enable for its lane is set. Bits 7:0 use lane `cfg_be[2]` and bits 15:8 use lane `cfg_be[3]`. Writing 0, or writing with the lane disabled, leaves the bit unchanged. Lanes 0 and 1 never affect the register.
- R10: If a set event and a write-1 clear reach the same sticky bit in the same cycle, the bit ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe for the command/status dword |
| cfg_be | input | 4 | Byte enables of the write; lanes 2 and 3 hold the status register |
| cfg_wdata | input | 32 | Write data of the dword |
| acpi_mode | input | 1 | Power-management mode; 1 hides the capability list |
| serr_en | input | 1 | System-error enable from the command register |
| ev_addr_perr_tgt | input | 1 | Address parity error on a normal target cycle |
| ev_data_perr_spec | input | 1 | Data parity error on a special cycle |
| ev_data_perr_mst | input | 1 | Data parity error while the device is bus master |
| ev_tgt_abort_sent | input | 1 | The device ended a target transaction with Target Abort |
| ev_tgt_abort_rcvd | input | 1 | A master memory cycle of the device ended with Target Abort |
| ev_mst_abort_rcvd | input | 1 | A master memory cycle of the device ended with Master Abort |
| status_o | output | 16 | Current status register value |
| serr_n_o | output | 1 | System-error output, active low |

## Verification
The two functions that can meet in one cycle are a hardware event that sets a sticky flag and a configuration write that clears the same flag. The bench provokes this by driving an abort strobe together with an all-ones write to both status lanes. It also drives a qualifying parity error with system errors enabled, again together with the all-ones clear. In each case it expects the targeted flags, together with the signalled-system-error flag, to read 1 afterwards, while the other sticky bits read 0. A write-only clear of the same bits on the row before shows that the clear path itself works.

// File: rtl/pci_stat_pkg.sv
package pci_stat_pkg;
  localparam int STAT_W = 16;
  localparam logic [STAT_W-1:0] STAT_RST = 16'h0210;
  localparam int CAP_POS = 4;
  localparam int DEVT_LO = 9;
  localparam logic [1:0] DEVT_MEDIUM = 2'b01;
  localparam int STICKY_N = 6;
  // sticky flag order: master data perr, target abort sent, target abort
  // received, master abort received, system error signalled, parity detected
  localparam int STICKY_POS [STICKY_N] = '{8, 11, 12, 13, 14, 15};
endpackage

// File: rtl/pci_stat_flag.sv
module pci_stat_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/pci_stat_serr.sv
module pci_stat_serr (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic addr_perr_i,
  input  logic spec_perr_i,
  output logic fire_o,
  output logic serr_n_o
);
  assign fire_o = enable_i & (addr_perr_i | spec_perr_i);

  always_ff @(posedge clk) begin
    if (rst) serr_n_o <= 1'b1;
    else     serr_n_o <= ~fire_o;
  end
endmodule

// File: rtl/pci_stat_reg.sv
module pci_stat_reg #(
  parameter int DW        = 32,
  parameter int STAT_LANE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [DW/8-1:0]      cfg_be,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic                 acpi_mode,
  input  logic                 serr_en,
  input  logic                 ev_addr_perr_tgt,
  input  logic                 ev_data_perr_spec,
  input  logic                 ev_data_perr_mst,
  input  logic                 ev_tgt_abort_sent,
  input  logic                 ev_tgt_abort_rcvd,
  input  logic                 ev_mst_abort_rcvd,
  output logic [15:0]          status_o,
  output logic                 serr_n_o
);
  import pci_stat_pkg::*;

  localparam int BE_W = DW / 8;

  logic                serr_fire;
  logic                cap_q;
  logic [STICKY_N-1:0] set_v;
  logic [STICKY_N-1:0] clr_v;
  logic [STICKY_N-1:0] flag_q;

  pci_stat_serr u_serr (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (serr_en),
    .addr_perr_i (ev_addr_perr_tgt),
    .spec_perr_i (ev_data_perr_spec),
    .fire_o      (serr_fire),
    .serr_n_o    (serr_n_o)
  );

  // event sources in sticky-flag order
  assign set_v = {ev_addr_perr_tgt | ev_data_perr_spec | ev_data_perr_mst,
                  serr_fire,
                  ev_mst_abort_rcvd,
                  ev_tgt_abort_rcvd,
                  ev_tgt_abort_sent,
                  ev_data_perr_mst};

  for (genvar k = 0; k < STICKY_N; k++) begin : g_flag
    localparam int POS  = STICKY_POS[k];
    localparam int LANE = STAT_LANE + POS / 8;
    localparam int DBIT = LANE * 8 + POS % 8;

    assign clr_v[k] = cfg_wr & cfg_be[LANE] & cfg_wdata[DBIT];

    pci_stat_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[k]),
      .clr_i (clr_v[k]),
      .q_o   (flag_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cap_q <= STAT_RST[CAP_POS];
    else     cap_q <= ~acpi_mode;
  end

  always_comb begin
    status_o = '0;
    status_o[CAP_POS] = cap_q;
    status_o[DEVT_LO +: 2] = DEVT_MEDIUM;
    for (int k = 0; k < STICKY_N; k++) status_o[STICKY_POS[k]] = flag_q[k];
  end

  logic unused_be;
  assign unused_be = ^{cfg_be[BE_W-1:0]};
endmodule

// File: rtl/pci_stat_reg_chk.sv
module pci_stat_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        acpi_mode,
  input logic        serr_en,
  input logic        ev_addr_perr_tgt,
  input logic        ev_data_perr_spec,
  input logic        ev_data_perr_mst,
  input logic        ev_tgt_abort_sent,
  input logic [15:0] status_o,
  input logic        serr_n_o
);
  assert_reset_val_R1: assert property (@(posedge clk)
    $past(rst) |-> (status_o == 16'h0210 && serr_n_o));

  assert_cap_inv_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_o[4] == !$past(acpi_mode)));

  assert_ro_fields_R3: assert property (@(posedge clk) disable iff (rst)
    (status_o[10:9] == 2'b01 && status_o[7:5] == 3'b0 && status_o[3:0] == 4'b0));

  assert_dpd_set_R4: assert property (@(posedge clk) disable iff (rst)
    ev_data_perr_mst |=> status_o[8]);

  assert_sta_set_R5: assert property (@(posedge clk) disable iff (rst)
    ev_tgt_abort_sent |=> status_o[11]);

  assert_dpe_set_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_addr_perr_tgt || ev_data_perr_spec || ev_data_perr_mst) |=> status_o[15]);

  assert_serr_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (!serr_n_o && !$past(rst)) |->
      ($past(serr_en) && ($past(ev_addr_perr_tgt) || $past(ev_data_perr_spec))));

  assert_serr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (serr_en && (ev_addr_perr_tgt || ev_data_perr_spec)) |=> !serr_n_o);

  assert_sse_with_serr_R8: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> status_o[14]);

  assert_w0_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (status_o[11] && !(cfg_wr && cfg_be[3] && cfg_wdata[27])) |=> status_o[11]);
endmodule

bind pci_stat_reg pci_stat_reg_chk u_chk (
  .clk               (clk),
  .rst               (rst),
  .cfg_wr            (cfg_wr),
  .cfg_be            (cfg_be),
  .cfg_wdata         (cfg_wdata),
  .acpi_mode         (acpi_mode),
  .serr_en           (serr_en),
  .ev_addr_perr_tgt  (ev_addr_perr_tgt),
  .ev_data_perr_spec (ev_data_perr_spec),
  .ev_data_perr_mst  (ev_data_perr_mst),
  .ev_tgt_abort_sent (ev_tgt_abort_sent),
  .status_o          (status_o),
  .serr_n_o          (serr_n_o)
);

// File: tb/pci_stat_reg_tb.sv
module pci_stat_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acpi_mode = 1'b0;
  logic        serr_en = 1'b0;
  logic [5:0]  ev = '0;
  logic [15:0] status_o;
  logic        serr_n_o;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  pci_stat_reg u_dut (
    .clk               (clk),
    .rst               (rst),
    .cfg_wr            (cfg_wr),
    .cfg_be            (cfg_be),
    .cfg_wdata         (cfg_wdata),
    .acpi_mode         (acpi_mode),
    .serr_en           (serr_en),
    .ev_addr_perr_tgt  (ev[0]),
    .ev_data_perr_spec (ev[1]),
    .ev_data_perr_mst  (ev[2]),
    .ev_tgt_abort_sent (ev[3]),
    .ev_tgt_abort_rcvd (ev[4]),
    .ev_mst_abort_rcvd (ev[5]),
    .status_o          (status_o),
    .serr_n_o          (serr_n_o)
  );

  // row: ev[6] wr be[4] wdata[32] acpi sen exp_status[16] exp_serr_n
  localparam int NV = 18;
  localparam logic [61:0] VEC [NV] = '{
    {6'b000000, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b0, 16'h0210, 1'b1}, // R1 idle
    {6'b010000, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b0, 16'h1210, 1'b1}, // R5 bit12
    {6'b000100, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b0, 16'h9310, 1'b1}, // R4 R6
    {6'b000001, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b0, 16'h9310, 1'b1}, // R6 R7 disabled
    {6'b000000, 1'b1, 4'h8, 32'h8000_0000, 1'b0, 1'b0, 16'h1310, 1'b1}, // R9 clear 15
    {6'b000001, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b1, 16'hD310, 1'b0}, // R7 R8 addr perr
    {6'b000000, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b1, 16'hD310, 1'b1}, // R7 one clock
    {6'b000010, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b1, 16'hD310, 1'b0}, // R7 special
    {6'b000000, 1'b0, 4'h0, 32'h0000_0000, 1'b1, 1'b0, 16'hD300, 1'b1}, // R2 cap off
    {6'b000000, 1'b1, 4'h4, 32'hFFFF_FFFF, 1'b1, 1'b0, 16'hD300, 1'b1}, // R3 low lane
    {6'b000000, 1'b1, 4'h3, 32'hFFFF_FFFF, 1'b1, 1'b0, 16'hD300, 1'b1}, // R9 lanes 0,1
    {6'b000000, 1'b1, 4'h8, 32'h0000_0000, 1'b1, 1'b0, 16'hD300, 1'b1}, // R9 write 0
    {6'b000000, 1'b1, 4'h8, 32'h4000_0000, 1'b1, 1'b0, 16'h9300, 1'b1}, // R9 clear 14
    {6'b101000, 1'b0, 4'h0, 32'h0000_0000, 1'b1, 1'b0, 16'hBB00, 1'b1}, // R5 bits 11,13
    {6'b000000, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 1'b0, 16'hBB10, 1'b1}, // R2 cap on
    {6'b000000, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 1'b0, 16'h0210, 1'b1}, // R9 R3 clear all
    {6'b001000, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 1'b0, 16'h0A10, 1'b1}, // R10 abort
    {6'b000001, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 1'b1, 16'hC210, 1'b0}  // R10 R8 serr
  };

  task automatic check(input string req, input logic [15:0] exp_s, input logic exp_n);
    total++;
    if (status_o !== exp_s || serr_n_o !== exp_n) begin
      bad++;
      $display("FAIL %s: status=%h serr_n=%b expected status=%h serr_n=%b",
               req, status_o, serr_n_o, exp_s, exp_n);
    end
  endtask

  task automatic idle();
    ev = '0; cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
  endtask

  initial begin : watchdog
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", 16'h0210, 1'b1);
    for (int i = 0; i < NV; i++) begin
      {ev, cfg_wr, cfg_be, cfg_wdata, acpi_mode, serr_en} = VEC[i][61:17];
      @(negedge clk);
      check($sformatf("row %0d (see row tag)", i), VEC[i][16:1], VEC[i][0]);
    end
    idle();
    serr_en = 1'b0;
    @(negedge clk);
    check("R7 back high", 16'hC210, 1'b1);
    // R1: reset wins over events and mode
    rst = 1'b1; acpi_mode = 1'b1; serr_en = 1'b1; ev = 6'b111111;
    @(negedge clk);
    check("R1 reset under events", 16'h0210, 1'b1);
    rst = 1'b0; ev = '0; serr_en = 1'b0;
    @(negedge clk);
    check("R2 cap follows mode after reset", 16'h0200, 1'b1);
    // R7: back-to-back qualifying events give back-to-back pulses
    acpi_mode = 1'b0; serr_en = 1'b1; ev = 6'b000010;
    @(negedge clk);
    check("R7 first pulse", 16'hC210, 1'b0);
    ev = 6'b000001;
    @(negedge clk);
    check("R7 second pulse", 16'hC210, 1'b0);
    ev = '0;
    @(negedge clk);
    check("R7 release", 16'hC210, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule